// File: doc/BRIEF.md
# Floating-Point Tag Word Reconstructor

This block rebuilds the full two-bit-per-register tag word of an eight-entry 80-bit floating-point register file. Its inputs are a compressed occupancy byte, with one bit per register (1 = occupied), and the register images, which come in as an array-shaped read port. Each occupied register gets a tag chosen from the class of the value it holds. An unoccupied register is tagged empty. The result goes to code that needs the long tag format, for example a state-save path that expands the compressed form.

The block uses one shared classifier and visits one register per clock. A start pulse accepted in IDLE or HOLD moves the controller to SCAN. SCAN visits registers 0 through 7 in order. After the last register, SCAN moves to HOLD and raises done. HOLD keeps the word and done until the next start, which moves the controller back to SCAN. Reset returns the controller to IDLE from any state.

The transitions are:
- IDLE→SCAN on start.
- SCAN→SCAN while the register index is below 7.
- SCAN→HOLD when the index is 7.
- HOLD→SCAN on start.

Each register image has this layout: sign in bit 79, a 15-bit exponent in bits 78:64, the explicit integer bit in bit 63 and the fraction in bits 62:0. The sign never affects the tag.

Top module: `ftag_rebuild`

## Requirements
- R1: A register whose occupancy bit is 0 gets tag 2'b11 (empty), whatever its contents.
- R2: An occupied register with exponent 0, integer bit 0 and fraction 0 gets tag 2'b01 (zero).
- R3: An occupied register with exponent 0 that is not a zero gets tag 2'b10 (special). This covers denormals and pseudo-denormals (integer bit 1).
- R4: An occupied register whose exponent is neither all zeros nor all ones gets tag 2'b00 (valid) if its integer bit is 1. If its integer bit is 0 (unnormal), it gets tag 2'b10.
- R5: An occupied register with an all-ones exponent gets tag 2'b10 in every case: infinity, NaN, pseudo-infinity and pseudo-NaN.
- R6: The tag of register i occupies bits 2i+1:2i of tag_word.
- R7: Let a start be accepted at clock edge E. Register i is written at edge E+1+i. done rises at edge E+8. busy is high for exactly those 8 cycles.
- R8: A start pulse that arrives while busy is high changes neither the scan order nor the timing of done.
- R9: While not busy and with no start, tag_word and done hold their values even if the inputs change. An accepted start clears both tag_word and done at its edge.
- R10: Synchronous reset clears tag_word and done and returns the controller to IDLE, including in the middle of a scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse; accepted only when not busy |
| occ_bits | input | 8 | Compressed occupancy bits, bit i for register i |
| fp_regs | input | 80 x 8 | Register images, array indexed by register number |
| tag_word | output | 16 | Reconstructed tag word, two bits per register |
| busy | output | 1 | High while the controller is in SCAN |
| done | output | 1 | High in HOLD after a complete scan |

## Verification
The two functions that can coincide are the final register write, which moves SCAN to HOLD and raises done, and the acceptance of a new start. The bench provokes this by pulsing start in the last SCAN cycle and also in the middle of a scan. Its behavioural model counts the scan position independently and expects both pulses to be ignored. It also pulses start in the first HOLD cycle and expects tag_word and done to clear at once. Every clock, the model's word, busy and done are compared with the ports, so any extra or shifted write shows up.

// File: rtl/ftag_pkg.sv
package ftag_pkg;

    typedef enum logic [1:0] {
        TAG_VALID   = 2'b00,
        TAG_ZERO    = 2'b01,
        TAG_SPECIAL = 2'b10,
        TAG_EMPTY   = 2'b11
    } tag_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2
    } ctrl_st_e;

endpackage

// File: rtl/ftag_classify.sv
module ftag_classify
    import ftag_pkg::*;
#(
    parameter int EXP_W  = 15,
    parameter int MANT_W = 64,
    localparam int VAL_W = 1 + EXP_W + MANT_W
) (
    input  logic [VAL_W-1:0] value,
    input  logic             live,
    output tag_e             tag
);

    logic [EXP_W-1:0]  expo;
    logic              int_bit;
    logic [MANT_W-2:0] frac;
    logic              sign_unused;
    logic              exp_min;
    logic              exp_max;

    assign expo        = value[MANT_W +: EXP_W];
    assign int_bit     = value[MANT_W-1];
    assign frac        = value[MANT_W-2:0];
    assign sign_unused = value[VAL_W-1];
    assign exp_min     = (expo == '0);
    assign exp_max     = (expo == '1);

    always_comb begin
        if (!live) begin
            tag = TAG_EMPTY;
        end else if (exp_min) begin
            tag = (!int_bit && frac == '0) ? TAG_ZERO : TAG_SPECIAL;
        end else if (exp_max) begin
            tag = TAG_SPECIAL;
        end else begin
            tag = int_bit ? TAG_VALID : TAG_SPECIAL;
        end
    end

endmodule

// File: rtl/ftag_ctrl.sv
module ftag_ctrl
    import ftag_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             accept,
    output logic             done,
    output logic [IDX_W-1:0] idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

    ctrl_st_e st_q, st_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start)       st_d = ST_SCAN;
            ST_SCAN: if (idx == LAST) st_d = ST_HOLD;
            ST_HOLD: if (start)       st_d = ST_SCAN;
            default:                  st_d = ST_IDLE;
        endcase
    end

    assign busy   = (st_q == ST_SCAN);
    assign accept = start && !busy;

    // outputs: register index and completion flag
    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            done <= 1'b0;
        end else if (accept) begin
            idx  <= '0;
            done <= 1'b0;
        end else if (busy) begin
            if (idx == LAST) begin
                idx  <= '0;
                done <= 1'b1;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    assert_done_on_last_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && idx == LAST) |=> (done && !busy));

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1));

    assert_start_restarts_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done && idx == '0));

    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (!busy && !done));

endmodule

// File: rtl/ftag_rebuild.sv
module ftag_rebuild
    import ftag_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int EXP_W    = 15,
    parameter int MANT_W   = 64,
    localparam int REG_W   = 1 + EXP_W + MANT_W,
    localparam int TAG_W   = 2,
    localparam int WORD_W  = TAG_W * NUM_REGS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [NUM_REGS-1:0] occ_bits,
    input  logic [REG_W-1:0]  fp_regs [NUM_REGS],
    output logic [WORD_W-1:0] tag_word,
    output logic              busy,
    output logic              done
);

    localparam int IDX_W = $clog2(NUM_REGS);

    logic             accept;
    logic [IDX_W-1:0] idx;
    tag_e             cur_tag;

    ftag_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .busy   (busy),
        .accept (accept),
        .done   (done),
        .idx    (idx)
    );

    ftag_classify #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_class (
        .value (fp_regs[idx]),
        .live  (occ_bits[idx]),
        .tag   (cur_tag)
    );

    // one field register per register-file entry
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst || accept) begin
                tag_word[g*TAG_W +: TAG_W] <= '0;
            end else if (busy && idx == IDX_W'(g)) begin
                tag_word[g*TAG_W +: TAG_W] <= cur_tag;
            end
        end
    end

    assert_empty_field_R1: assert property (@(posedge clk) disable iff (rst)
        (busy && !occ_bits[idx]) |=> (tag_word[TAG_W*$past(idx) +: TAG_W] == TAG_EMPTY));

    assert_word_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(tag_word));

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (tag_word == '0));

endmodule

// File: tb/test_ftag_rebuild.sv
module test_ftag_rebuild;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  occ_bits = 8'hFF;
    logic [79:0] fp_regs [NR];
    logic [15:0] tag_word;
    logic        busy, done;

    int n_chk = 0;
    int n_fail = 0;
    string phase = "R10";

    int          m_cnt = -1;
    logic [15:0] m_word = '0;
    logic        m_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ftag_rebuild i_ftag_rebuild (
        .clk(clk), .rst(rst), .start(start), .occ_bits(occ_bits),
        .fp_regs(fp_regs), .tag_word(tag_word), .busy(busy), .done(done)
    );

    function automatic logic [79:0] mk(bit s, logic [14:0] e, bit j, logic [62:0] f);
        return {s, e, j, f};
    endfunction

    function automatic logic [1:0] ref_tag(bit live, logic [79:0] v);
        if (!live)                return 2'b11;
        if (v[78:64] == 15'h7FFF) return 2'b10;
        if (v[78:64] == 15'h0000) return (v[63:0] == 64'd0) ? 2'b01 : 2'b10;
        return v[63] ? 2'b00 : 2'b10;
    endfunction

    function automatic string req_of(bit live, logic [79:0] v);
        if (!live)                return "R1";
        if (v[78:64] == 15'h7FFF) return "R5";
        if (v[78:64] == 15'h0000) return (v[63:0] == 64'd0) ? "R2" : "R3";
        return "R4";
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        if (rst) begin
            m_word = '0; m_done = 1'b0; m_cnt = -1;
        end else if (m_cnt >= 0) begin
            m_word[2*m_cnt +: 2] = ref_tag(occ_bits[m_cnt], fp_regs[m_cnt]);
            if (m_cnt == NR-1) begin m_done = 1'b1; m_cnt = -1; end
            else m_cnt++;
        end else if (start) begin
            m_word = '0; m_done = 1'b0; m_cnt = 0;
        end
        @(negedge clk);
        check(phase, tag_word, m_word, "word");
        check(phase, {15'd0, busy}, {15'd0, (m_cnt >= 0)}, "busy");
        check(phase, {15'd0, done}, {15'd0, m_done}, "done");
    endtask

    task automatic run_scan();
        start = 1'b1; step(); start = 1'b0;
        for (int k = 0; k < NR-1; k++) step();
        check("R7", {15'd0, done}, 16'd0, "done before 8th");
        step();
        check("R7", {15'd0, done}, 16'd1, "done at 8th");
        for (int i = 0; i < NR; i++)
            check(req_of(occ_bits[i], fp_regs[i]), {14'd0, tag_word[2*i +: 2]},
                  {14'd0, ref_tag(occ_bits[i], fp_regs[i])}, $sformatf("field %0d", i));
    endtask

    task automatic load_set_a();
        fp_regs[0] = mk(0, 15'h0000, 0, 63'd0);                 // zero
        fp_regs[1] = mk(0, 15'h0000, 0, 63'd1);                 // denormal
        fp_regs[2] = mk(1, 15'h0000, 1, 63'd0);                 // pseudo-denormal
        fp_regs[3] = mk(0, 15'h3FFF, 1, 63'h123456789);         // normal
        fp_regs[4] = mk(0, 15'h3FFF, 0, 63'h55);                // unnormal
        fp_regs[5] = mk(1, 15'h7FFF, 1, 63'd0);                 // infinity
        fp_regs[6] = mk(0, 15'h7FFF, 1, 63'h4000000000000000);  // NaN
        fp_regs[7] = mk(0, 15'h7FFF, 0, 63'd0);                 // pseudo-infinity
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        load_set_a();
        @(negedge clk);
        phase = "R10";
        for (int k = 0; k < 3; k++) step();
        check("R10", tag_word, 16'h0000, "reset word");
        rst = 1'b0;
        step();

        phase = "R6"; occ_bits = 8'hFF; run_scan();
        check("R6", tag_word, 16'b10_10_10_10_00_10_10_01, "placement");

        phase = "R1"; occ_bits = 8'hA5; run_scan();

        phase = "R6";
        begin
            logic [79:0] tmp [NR];
            for (int i = 0; i < NR; i++) tmp[i] = fp_regs[i];
            for (int i = 0; i < NR; i++) fp_regs[i] = tmp[(i+3) % NR];
        end
        occ_bits = 8'h3C; run_scan();

        phase = "R4";
        fp_regs[0] = mk(1, 15'h0000, 0, 63'd0);                 // negative zero
        fp_regs[1] = mk(0, 15'h0001, 0, 63'd0);                 // unnormal, smallest exponent
        fp_regs[2] = mk(0, 15'h7FFE, 1, 63'h7FFFFFFFFFFFFFFF);  // normal, largest exponent
        fp_regs[3] = mk(0, 15'h0000, 0, 63'h4000000000000000);  // denormal
        fp_regs[4] = mk(1, 15'h7FFF, 0, 63'd9);                 // pseudo-NaN
        fp_regs[5] = mk(1, 15'h0001, 1, 63'd0);                 // normal
        fp_regs[6] = mk(0, 15'h0000, 1, 63'h7);                 // pseudo-denormal
        fp_regs[7] = mk(0, 15'h7FFF, 1, 63'd0);                 // infinity
        occ_bits = 8'hFF; run_scan();

        phase = "R9";
        for (int k = 0; k < 5; k++) begin
            occ_bits = occ_bits ^ 8'h5A;
            fp_regs[k] = mk(0, 15'h2000, 1, 63'd3);
            step();
        end
        check("R9", {15'd0, done}, 16'd1, "done held");

        phase = "R8"; occ_bits = 8'hFF; load_set_a();
        start = 1'b1; step(); start = 1'b0;
        for (int k = 1; k <= NR; k++) begin
            if (k == 3 || k == NR) start = 1'b1;
            step();
            start = 1'b0;
            if (k == NR - 1) check("R8", {15'd0, done}, 16'd0, "done early");
        end
        check("R8", {15'd0, done}, 16'd1, "done on time");
        check("R8", tag_word, 16'b10_10_10_10_00_10_10_01, "word after extra starts");

        phase = "R9";
        start = 1'b1; step(); start = 1'b0;
        check("R9", {15'd0, done}, 16'd0, "restart clears done");
        check("R9", tag_word, 16'd0, "restart clears word");

        phase = "R10";
        for (int k = 0; k < 3; k++) step();
        rst = 1'b1; step(); rst = 1'b0;
        check("R10", tag_word, 16'd0, "mid-scan reset word");
        check("R10", {15'd0, busy}, 16'd0, "mid-scan reset busy");
        for (int k = 0; k < 3; k++) step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule